// File: doc/BRIEF.md
# Greedy-then-oldest warp scheduler

The block picks, every cycle, one warp out of a pool of resident warps to issue its next instruction. Warps join the pool through an arrival strobe and leave it through a retire strobe. Each resident warp carries an age rank that is fixed by the order of arrival. It can be held back by three independent stall causes: an outstanding memory access, an unresolved operand dependency, or a barrier. It is also held back when the execution unit class it needs is busy.

Selection is greedy. The warp that issued last cycle keeps issuing for as long as it stays eligible. When it stops being eligible, the oldest eligible warp is chosen in the same cycle, so a switch costs no cycles. Each warp owns its program counter outside this block, and a switch only changes the warp index presented to that per-warp state. The pool is sized by a parameter, with a maximum of 64 warps.

Top module: `gto_sched`

## Requirements
- R1: While the warp issued in the previous cycle is still eligible, it is issued again, even if older warps are eligible.
- R2: When the previously issued warp is not eligible and some warp is eligible, `issue_valid_o` stays high in that same cycle and `issue_id_o` is the oldest eligible warp.
- R3: A warp is not eligible while its bit in `mem_wait_i`, `dep_wait_i` or `bar_wait_i` is set. Each of the three blocks issue on its own.
- R4: Warp w needs the unit class `unit_need_i[w*UNIT_W +: UNIT_W]`. It is not eligible unless `unit_free_i` has the bit for that class set.
- R5: When no warp is eligible, `issue_valid_o` is low and the greedy choice is forgotten. The next issue goes to the oldest eligible warp.
- R6: Age follows arrival order. A warp that retires and arrives again becomes younger than every other resident warp.
- R7: A warp whose retire strobe is present in a cycle is not issued in that cycle. If it was the greedy warp, the oldest other eligible warp issues in that same cycle.
- R8: While `rst_ni` is low, no warp is resident and `issue_valid_o` is low. After reset, nothing issues until a warp has arrived.
- R9: An arrival for a warp that is already resident leaves its age unchanged. A retire for a warp that is not resident has no effect.
- R10: A warp becomes eligible in the cycle after its arrival strobe, never in the arrival cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arrive_i | input | 1 | A warp joins the pool this cycle |
| arrive_id_i | input | ID_W | Index of the arriving warp |
| retire_i | input | 1 | A warp leaves the pool this cycle |
| retire_id_i | input | ID_W | Index of the retiring warp |
| mem_wait_i | input | NUM_WARPS | Per-warp outstanding memory access |
| dep_wait_i | input | NUM_WARPS | Per-warp operand dependency pending |
| bar_wait_i | input | NUM_WARPS | Per-warp waiting at a barrier |
| unit_need_i | input | NUM_WARPS*UNIT_W | Per-warp execution unit class needed next |
| unit_free_i | input | NUM_UNITS | Per-class unit availability |
| issue_valid_o | output | 1 | A warp issues this cycle |
| issue_id_o | output | ID_W | Index of the issuing warp |

## Verification
The scheduler has three pieces of state: the greedy pointer, the resident bits and the age ranks. A wrong value in any of them reaches the ports through the warp chosen in the same cycle, so it cannot stay hidden. A greedy pointer that is not cleared shows up right after an idle cycle as a young warp issuing ahead of an older one. A corrupted age rank stays invisible until the warps ranked above it are stalled. For that reason the tests stall chosen subsets of warps so that each age position is exposed in turn, including after a re-arrival and after a spurious arrival or retire.

// File: rtl/gto_pkg.sv
package gto_pkg;
  localparam int unsigned MAX_WARPS = 64;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/gto_elig.sv
module gto_elig #(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned NUM_UNITS = 2,
  parameter int unsigned ID_W      = 3,
  parameter int unsigned UNIT_W    = 1
) (
  input  logic [NUM_WARPS-1:0]        valid_i,
  input  logic [NUM_WARPS-1:0]        mem_wait_i,
  input  logic [NUM_WARPS-1:0]        dep_wait_i,
  input  logic [NUM_WARPS-1:0]        bar_wait_i,
  input  logic [NUM_WARPS*UNIT_W-1:0] unit_need_i,
  input  logic [NUM_UNITS-1:0]        unit_free_i,
  input  logic                        retire_i,
  input  logic [ID_W-1:0]             retire_id_i,
  output logic [NUM_WARPS-1:0]        elig_o
);
  localparam int unsigned FREE_W = 2 ** UNIT_W;

  // classes beyond NUM_UNITS read as busy
  logic [FREE_W-1:0] free_ext;
  assign free_ext = FREE_W'(unit_free_i);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic [UNIT_W-1:0] cls;
    logic              stalled, leaving;
    assign cls       = unit_need_i[w*UNIT_W +: UNIT_W];
    assign stalled   = mem_wait_i[w] | dep_wait_i[w] | bar_wait_i[w];
    assign leaving   = retire_i && (retire_id_i == ID_W'(w));
    assign elig_o[w] = valid_i[w] & ~stalled & free_ext[cls] & ~leaving;
  end
endmodule

// File: rtl/gto_age_table.sv
module gto_age_table #(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned ID_W      = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      arrive_i,
  input  logic [ID_W-1:0]           arrive_id_i,
  input  logic                      retire_i,
  input  logic [ID_W-1:0]           retire_id_i,
  output logic [NUM_WARPS-1:0]      valid_o,
  output logic [NUM_WARPS*ID_W-1:0] stamp_o
);
  localparam int unsigned CNT_W = ID_W + 1;

  logic [NUM_WARPS-1:0] valid_q;
  logic [ID_W-1:0]      stamp_q [NUM_WARPS];
  logic [CNT_W-1:0]     count_q;
  logic                 arr_ok, ret_ok;
  logic [ID_W-1:0]      ret_stamp, new_stamp;

  assign arr_ok    = arrive_i & ~valid_q[arrive_id_i];
  assign ret_ok    = retire_i & valid_q[retire_id_i];
  assign ret_stamp = stamp_q[retire_id_i];
  // ranks stay dense: the newcomer takes the slot just past the survivors
  assign new_stamp = ID_W'(count_q - CNT_W'(ret_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_q + CNT_W'(arr_ok) - CNT_W'(ret_ok);
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[w] <= 1'b0;
        stamp_q[w] <= '0;
      end else if (arr_ok && arrive_id_i == ID_W'(w)) begin
        valid_q[w] <= 1'b1;
        stamp_q[w] <= new_stamp;
      end else if (ret_ok && retire_id_i == ID_W'(w)) begin
        valid_q[w] <= 1'b0;
        stamp_q[w] <= '0;
      end else if (ret_ok && valid_q[w] && stamp_q[w] > ret_stamp) begin
        stamp_q[w] <= stamp_q[w] - 1'b1;
      end
    end
    assign stamp_o[w*ID_W +: ID_W] = stamp_q[w];
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/gto_oldest_pick.sv
module gto_oldest_pick #(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned ID_W      = 3
) (
  input  logic [NUM_WARPS-1:0]      elig_i,
  input  logic [NUM_WARPS*ID_W-1:0] stamp_i,
  output logic                      any_o,
  output logic [ID_W-1:0]           id_o
);
  logic [ID_W-1:0] best;

  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    best  = '1;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (elig_i[w] && (!any_o || stamp_i[w*ID_W +: ID_W] < best)) begin
        any_o = 1'b1;
        id_o  = ID_W'(w);
        best  = stamp_i[w*ID_W +: ID_W];
      end
    end
  end
endmodule

// File: rtl/gto_sched.sv
module gto_sched
  import gto_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned NUM_UNITS = 2,
  localparam int unsigned ID_W     = idx_w(NUM_WARPS),
  localparam int unsigned UNIT_W   = idx_w(NUM_UNITS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        arrive_i,
  input  logic [ID_W-1:0]             arrive_id_i,
  input  logic                        retire_i,
  input  logic [ID_W-1:0]             retire_id_i,
  input  logic [NUM_WARPS-1:0]        mem_wait_i,
  input  logic [NUM_WARPS-1:0]        dep_wait_i,
  input  logic [NUM_WARPS-1:0]        bar_wait_i,
  input  logic [NUM_WARPS*UNIT_W-1:0] unit_need_i,
  input  logic [NUM_UNITS-1:0]        unit_free_i,
  output logic                        issue_valid_o,
  output logic [ID_W-1:0]             issue_id_o
);
  if (NUM_WARPS < 2 || NUM_WARPS > MAX_WARPS) begin : g_bad_size
    $error("gto_sched: NUM_WARPS out of range");
  end

  logic [NUM_WARPS-1:0]      warp_vld;
  logic [NUM_WARPS*ID_W-1:0] warp_stamp;
  logic [NUM_WARPS-1:0]      elig;
  logic                      old_any, keep;
  logic [ID_W-1:0]           old_id;
  logic                      cur_vld_q;
  logic [ID_W-1:0]           cur_id_q;

  gto_age_table #(.NUM_WARPS(NUM_WARPS), .ID_W(ID_W)) u_age (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arrive_i    (arrive_i),
    .arrive_id_i (arrive_id_i),
    .retire_i    (retire_i),
    .retire_id_i (retire_id_i),
    .valid_o     (warp_vld),
    .stamp_o     (warp_stamp)
  );

  gto_elig #(
    .NUM_WARPS(NUM_WARPS), .NUM_UNITS(NUM_UNITS), .ID_W(ID_W), .UNIT_W(UNIT_W)
  ) u_elig (
    .valid_i     (warp_vld),
    .mem_wait_i  (mem_wait_i),
    .dep_wait_i  (dep_wait_i),
    .bar_wait_i  (bar_wait_i),
    .unit_need_i (unit_need_i),
    .unit_free_i (unit_free_i),
    .retire_i    (retire_i),
    .retire_id_i (retire_id_i),
    .elig_o      (elig)
  );

  gto_oldest_pick #(.NUM_WARPS(NUM_WARPS), .ID_W(ID_W)) u_pick (
    .elig_i  (elig),
    .stamp_i (warp_stamp),
    .any_o   (old_any),
    .id_o    (old_id)
  );

  // greedy first, oldest as fallback in the same cycle
  assign keep          = cur_vld_q & elig[cur_id_q];
  assign issue_valid_o = keep | old_any;
  assign issue_id_o    = keep ? cur_id_q : old_id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_vld_q <= 1'b0;
      cur_id_q  <= '0;
    end else begin
      cur_vld_q <= issue_valid_o;
      cur_id_q  <= issue_valid_o ? issue_id_o : '0;
    end
  end
endmodule

// File: rtl/gto_sched_chk.sv
module gto_sched_chk
  import gto_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned NUM_UNITS = 2,
  localparam int unsigned ID_W     = idx_w(NUM_WARPS),
  localparam int unsigned UNIT_W   = idx_w(NUM_UNITS)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        arrive_i,
  input logic [ID_W-1:0]             arrive_id_i,
  input logic                        retire_i,
  input logic [ID_W-1:0]             retire_id_i,
  input logic [NUM_WARPS-1:0]        mem_wait_i,
  input logic [NUM_WARPS-1:0]        dep_wait_i,
  input logic [NUM_WARPS-1:0]        bar_wait_i,
  input logic [NUM_WARPS*UNIT_W-1:0] unit_need_i,
  input logic [NUM_UNITS-1:0]        unit_free_i,
  input logic                        issue_valid_o,
  input logic [ID_W-1:0]             issue_id_o,
  input logic [NUM_WARPS-1:0]        warp_vld
);
  localparam int unsigned FREE_W = 2 ** UNIT_W;

  logic [FREE_W-1:0]    free_ext;
  logic [NUM_WARPS-1:0] ok;

  assign free_ext = FREE_W'(unit_free_i);

  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++) begin
      ok[w] = warp_vld[w] && !mem_wait_i[w] && !dep_wait_i[w] && !bar_wait_i[w]
              && free_ext[unit_need_i[w*UNIT_W +: UNIT_W]]
              && !(retire_i && retire_id_i == ID_W'(w));
    end
  end

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (!issue_valid_o); // R8
    end
  end

  AST_ISSUE_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> ok[issue_id_o]); // R3
  AST_IDLE_WHEN_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok == '0) |-> !issue_valid_o); // R5
  AST_SWITCH_NO_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok != '0) |-> issue_valid_o); // R2
  AST_GREEDY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(issue_valid_o) && ok[$past(issue_id_o)]) |-> (issue_id_o == $past(issue_id_o))); // R1
  AST_NO_RETIRING_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && retire_i) |-> (issue_id_o != retire_id_i)); // R7
  AST_NO_ARRIVAL_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && arrive_i && !warp_vld[arrive_id_i]) |-> (issue_id_o != arrive_id_i)); // R10
endmodule

bind gto_sched gto_sched_chk #(.NUM_WARPS(NUM_WARPS), .NUM_UNITS(NUM_UNITS)) u_chk (.*);

// File: tb/gto_sched_tb.sv
`timescale 1ns/1ps
module gto_sched_tb_top;
  localparam int NW = 8;
  localparam int NU = 2;
  localparam int IDW = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           arrive_i = 1'b0;
  logic [IDW-1:0] arrive_id_i = '0;
  logic           retire_i = 1'b0;
  logic [IDW-1:0] retire_id_i = '0;
  logic [NW-1:0]  mem_wait_i = '0, dep_wait_i = '0, bar_wait_i = '0;
  logic [NW-1:0]  unit_need_i = '0;
  logic [NU-1:0]  unit_free_i = '1;
  logic           issue_valid_o;
  logic [IDW-1:0] issue_id_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cyc = 0;

  // reference model
  int order[NW];
  int ocnt = 0;
  bit res[NW];
  int cur = -1;

  always #5 clk_i = ~clk_i;

  gto_sched #(.NUM_WARPS(NW), .NUM_UNITS(NU)) dut_i (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 5000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic bit m_elig(int w);
    return res[w] && !mem_wait_i[w] && !dep_wait_i[w] && !bar_wait_i[w]
           && unit_free_i[unit_need_i[w]] && !(retire_i && int'(retire_id_i) == w);
  endfunction

  function automatic int exp_pick();
    if (cur >= 0 && m_elig(cur)) return cur;
    for (int i = 0; i < ocnt; i++) if (m_elig(order[i])) return order[i];
    return -1;
  endfunction

  task automatic check_issue(string req, int e);
    bit ok;
    checks++;
    ok = (e < 0) ? !issue_valid_o : (issue_valid_o && int'(issue_id_o) == e);
    if (!ok) begin
      fails++;
      $display("FAIL %s: valid=%0b id=%0d expected=%0d (-1 idle)", req, issue_valid_o, issue_id_o, e);
    end
  endtask

  // inputs were set just after a falling edge; check mid-cycle, then advance model
  task automatic step(string req);
    int e;
    #1;
    e = exp_pick();
    check_issue(req, e);
    @(posedge clk_i);
    cur = e;
    if (retire_i && res[retire_id_i]) begin
      int k = 0;
      res[retire_id_i] = 1'b0;
      for (int i = 0; i < ocnt; i++) if (order[i] != int'(retire_id_i)) begin order[k] = order[i]; k++; end
      ocnt = k;
    end
    if (arrive_i && !res[arrive_id_i]) begin
      res[arrive_id_i] = 1'b1;
      order[ocnt] = int'(arrive_id_i);
      ocnt++;
    end
    @(negedge clk_i);
    arrive_i = 1'b0;
    retire_i = 1'b0;
  endtask

  task automatic t_reset();
    #1 check_issue("R8 in reset", -1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step("R8 empty pool");
  endtask

  task automatic t_arrivals();
    arrive_i = 1'b1; arrive_id_i = 3'd2; step("R10 arrival cycle");
    arrive_i = 1'b1; arrive_id_i = 3'd5; step("R1 first issue");
    arrive_i = 1'b1; arrive_id_i = 3'd1; step("R1 hold");
    step("R1 hold with three resident");
  endtask

  task automatic t_stall_causes();
    mem_wait_i[2] = 1'b1; step("R2 switch on memory wait");
    mem_wait_i[2] = 1'b0; step("R1 stay on new warp");
    dep_wait_i[5] = 1'b1; step("R3 dependency blocks");
    dep_wait_i[5] = 1'b0; bar_wait_i[2] = 1'b1; step("R3 barrier blocks");
    bar_wait_i[2] = 1'b0; step("R1 hold after release");
  endtask

  task automatic t_resource();
    unit_need_i[5] = 1'b1; unit_free_i = 2'b01; step("R4 class busy");
    unit_free_i = 2'b11; step("R4 class free, greedy");
    unit_need_i = '0;
  endtask

  task automatic t_idle();
    mem_wait_i[2] = 1'b1; mem_wait_i[5] = 1'b1; step("R2 youngest left");
    mem_wait_i = '0; bar_wait_i = '1; step("R5 none eligible");
    bar_wait_i = '0; step("R5 pointer cleared, oldest");
  endtask

  task automatic t_retire();
    retire_i = 1'b1; retire_id_i = 3'd2; step("R7 retire greedy warp");
    arrive_i = 1'b1; arrive_id_i = 3'd2; step("R10 re-arrival");
    mem_wait_i[5] = 1'b1; mem_wait_i[1] = 1'b1; step("R6 re-arrived warp");
    mem_wait_i = '0; mem_wait_i[2] = 1'b1; step("R6 re-arrived is youngest");
    mem_wait_i = '0;
  endtask

  task automatic t_ignore();
    arrive_i = 1'b1; arrive_id_i = 3'd5; step("R9 duplicate arrival");
    mem_wait_i[5] = 1'b1; step("R9 move off warp 5");
    mem_wait_i = '0; mem_wait_i[1] = 1'b1; step("R9 warp 5 still oldest");
    mem_wait_i = '0;
    retire_i = 1'b1; retire_id_i = 3'd7; step("R9 stray retire");
    arrive_i = 1'b1; arrive_id_i = 3'd7; step("R10 late arrival");
    mem_wait_i[5] = 1'b1; mem_wait_i[1] = 1'b1; mem_wait_i[2] = 1'b1; step("R6 newest warp last");
    mem_wait_i = '0; step("R1 hold newest");
  endtask

  initial begin
    for (int i = 0; i < NW; i++) res[i] = 1'b0;
    t_reset();
    t_arrivals();
    t_stall_causes();
    t_resource();
    t_idle();
    t_retire();
    t_ignore();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule